// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Clean Output Gating

This block derives a slower clock from its reference clock. The ratio is a power of two chosen by a 3-bit exponent code, and a separate gate bit starts and stops the output. Both settings sit in two byte-wide registers reached over a plain register bus: an address, write data, a write strobe and combinational read data. Each copy answers only at its own base address, which is a parameter, so several copies can share one register space 0x100 apart.

The output starts and stops only at the end of a full divided period. It never emits a pulse shorter than half a reference period, and it rests low while stopped. A new ratio written while the output runs is held back until the current period ends. A new ratio written while the output is stopped takes effect at once. For divide-by-one the output is the reference clock passed through a gate that opens and closes only while the reference clock is low. For every other ratio the output comes from a register with a 50% duty cycle.

Top module: `pow2_clkdiv`

## Requirements
- R1: After reset both registers read 0 (ratio code 0, gate clear) and the output is low with no rising edge.
- R2: The ratio code is bits [2:0] of the register at base+0x43. For codes 1 to 7 the output period is 2^(code-1) reference cycles, and the output is high for the first half of each period (for divide-by-one, while the reference clock is high).
- R3: Ratio code 0 gives the same output as code 1: divide-by-one.
- R4: The gate is bit 7 of the register at base+0x46 and reads back as written. In both registers, bits that are not implemented read 0 and writes to them have no effect.
- R5: Once a write sets the gate, the first rising output edge comes no more than 2+3·div reference cycles after the write edge.
- R6: Once a write clears the gate, the output is low within 3·div reference cycles and stays low.
- R7: The output starts, stops and changes ratio only at a period boundary. No high or low pulse is shorter than half a reference period.
- R8: A ratio write while the output runs reads back at once. It takes effect only after the current period completes, so that period keeps its old length.
- R9: Only base+0x43 and base+0x46 are decoded. Every other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge of clk_i |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| div_clk_o | output | 1 | Divided, gated clock output |

## Verification
The assertions watch, on every cycle, that a stopped divider holds its phase low and that a set gate starts the divider on the next edge. They also watch that a stop completes within one divided period, that the applied exponent never changes in mid-period, and that foreign writes and unused bits leave the registers untouched. Actual period and duty cycle can only be seen at the output pin. So can the start and stop latencies measured from the write edge, the divide-by-one pass-through, the absence of runt pulses across a ratio change, and the old period being kept after a write made while running. The bench shows these with time-stamped edges under directed and seeded random ratio sequences.

// File: rtl/pow2_clkdiv_pkg.sv
`timescale 1ns/1ps
package pow2_clkdiv_pkg;
    // Register offsets from the instance base; software relies on these.
    localparam logic [7:0] RATIO_OFS = 8'h43;
    localparam logic [7:0] GATE_OFS  = 8'h46;
    localparam int         GATE_BIT  = 7;
    localparam int         CODE_W    = 3;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
    import pow2_clkdiv_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [CODE_W-1:0] code_o,
    output logic              gate_o
);
    localparam logic [ADDR_W-1:0] RATIO_ADDR = BASE_ADDR + ADDR_W'(RATIO_OFS);
    localparam logic [ADDR_W-1:0] GATE_ADDR  = BASE_ADDR + ADDR_W'(GATE_OFS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              gate;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_ratio, hit_gate;
    logic  unused_wdata;

    assign hit_ratio    = (bus_addr_i == RATIO_ADDR);
    assign hit_gate     = (bus_addr_i == GATE_ADDR);
    assign unused_wdata = ^bus_wdata_i;

    always_comb begin
        regs_d = regs_q;
        if (bus_we_i && hit_ratio) regs_d.code = bus_wdata_i[CODE_W-1:0];
        if (bus_we_i && hit_gate)  regs_d.gate = bus_wdata_i[GATE_BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit_ratio)     bus_rdata_o[CODE_W-1:0] = regs_q.code;
        else if (hit_gate) bus_rdata_o[GATE_BIT]   = regs_q.gate;
    end

    assign code_o = regs_q.code;
    assign gate_o = regs_q.gate;

    assert_unused_ratio_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_ratio |-> (bus_rdata_o[DATA_W-1:CODE_W] == '0));
    assert_unused_gate_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_gate |-> (bus_rdata_o[GATE_BIT-1:0] == '0));
    assert_foreign_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && !hit_ratio && !hit_gate) |=> ($stable(code_o) && $stable(gate_o)));
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              gate_i,
    output logic              phase_o,
    output logic              fast_o
);
    localparam int MAX_EXP = (1 << CODE_W) - 2;
    localparam int EXP_W   = $clog2(MAX_EXP + 1);
    localparam int CNT_W   = MAX_EXP;

    typedef struct packed {
        logic             run;
        logic [EXP_W-1:0] expo;
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } core_t;

    core_t            s_d, s_q;
    logic [EXP_W-1:0] req_exp;
    logic [CNT_W-1:0] last_cnt, half_d;
    logic             at_end;

    // Code 0 aliases to code 1 (exponent 0, divide-by-one).
    assign req_exp  = (code_i == '0) ? '0 : EXP_W'(code_i - CODE_W'(1));
    assign last_cnt = (CNT_W'(1) << s_q.expo) - CNT_W'(1);
    assign at_end   = (s_q.cnt == last_cnt);

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            s_d.expo = req_exp;
            s_d.cnt  = '0;
            s_d.run  = gate_i;
        end else if (at_end) begin
            s_d.expo = req_exp;
            s_d.cnt  = '0;
            s_d.run  = gate_i;
        end else begin
            s_d.cnt  = s_q.cnt + CNT_W'(1);
        end
        half_d = (s_d.expo == '0) ? '0 : (CNT_W'(1) << (s_d.expo - EXP_W'(1)));
        s_d.phase = s_d.run && (s_d.expo != '0) && (s_d.cnt < half_d);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign phase_o = s_q.phase;
    assign fast_o  = s_q.run && (s_q.expo == '0);

    // Checker state: cycles spent running after the gate dropped.
    logic [CNT_W:0] stop_wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 stop_wait_q <= '0;
        else if (s_q.run && !gate_i) stop_wait_q <= stop_wait_q + (CNT_W+1)'(1);
        else                         stop_wait_q <= '0;
    end

    assert_low_when_stopped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.run |-> !s_q.phase);
    assert_stop_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_wait_q <= ((CNT_W+1)'(1) << s_q.expo));
    assert_start_next_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_i && !s_q.run) |=> s_q.run);
    assert_ratio_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && s_q.cnt != '0) |-> $stable(s_q.expo));
endmodule

// File: rtl/clkdiv_outgate.sv
`timescale 1ns/1ps
module clkdiv_outgate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fast_i,
    input  logic phase_i,
    output logic clk_o
);
    // Gate for divide-by-one, updated while the reference clock is low.
    logic open_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) open_q <= 1'b0;
        else         open_q <= fast_i;
    end

    assign clk_o = (clk_i & open_q) | phase_i;

    assert_fast_mode_no_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fast_i |-> !phase_i);
endmodule

// File: rtl/pow2_clkdiv.sv
`timescale 1ns/1ps
module pow2_clkdiv
    import pow2_clkdiv_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              div_clk_o
);
    logic [CODE_W-1:0] code;
    logic              gate, phase, fast;

    clkdiv_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) regs_i (
        .clk_i, .rst_ni, .bus_addr_i, .bus_wdata_i, .bus_we_i, .bus_rdata_o,
        .code_o(code), .gate_o(gate)
    );

    clkdiv_core #(.CODE_W(CODE_W)) core_i (
        .clk_i, .rst_ni, .code_i(code), .gate_i(gate),
        .phase_o(phase), .fast_o(fast)
    );

    clkdiv_outgate out_i (
        .clk_i, .rst_ni, .fast_i(fast), .phase_i(phase), .clk_o(div_clk_o)
    );
endmodule

// File: tb/pow2_clkdiv_tb_top.sv
`timescale 1ns/1ps
module pow2_clkdiv_tb_top;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int BASE   = 'h100;
    localparam int RATIO  = BASE + 'h43;
    localparam int GATE   = BASE + 'h46;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              we = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              dclk;

    int      checks = 0, errors = 0, rises = 0, runts = 0;
    bit      watch = 0, mark = 0, done = 0;
    realtime last_edge = 0.0, first_rise = 0.0, t_wr = 0.0;

    pow2_clkdiv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(ADDR_W'(BASE))) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_we_i(we), .bus_rdata_o(rdata), .div_clk_o(dclk)
    );

    always #2.5 clk = ~clk;

    // Edge monitor: counts rising edges and flags pulses shorter than 2.5 ns (R7).
    always @(dclk) begin
        if (watch) begin
            if ($realtime - last_edge < 2.4) runts++;
            last_edge = $realtime;
            if (dclk === 1'b1) begin
                rises++;
                if (mark) begin first_rise = $realtime; mark = 0; end
            end
        end
    end

    function automatic int div_of(int code);
        return (code == 0) ? 1 : (1 << (code - 1));
    endfunction

    function automatic longint ps(realtime t);
        return longint'(t * 1000.0);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_le(string tag, longint act, longint bound);
        checks++;
        if (act > bound) begin
            errors++;
            $display("FAIL %s: actual %0d expected <= %0d", tag, act, bound);
        end
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = DATA_W'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        t_wr = $realtime - 2.5;
    endtask

    task automatic bus_read(int a, output int d);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1 d = int'(rdata);
    endtask

    task automatic measure(int div, string tag);
        realtime t0, th, t1;
        @(posedge dclk) t0 = $realtime;
        @(negedge dclk) th = $realtime;
        @(posedge dclk) t1 = $realtime;
        chk({tag, " R2 period ps"}, ps(t1 - t0), longint'(div) * 5000);
        chk({tag, " R2 high ps"}, ps(th - t0), longint'(div) * 2500);
    endtask

    task automatic run_case(int code);
        int div, rd, r0, r1;
        div = div_of(code);
        bus_write(RATIO, {$urandom_range(31, 0), 3'(code)});
        bus_read(RATIO, rd);
        chk("R4 ratio readback", rd, code);
        r0 = rises; mark = 1;
        bus_write(GATE, 'h80 | $urandom_range(127, 0));
        repeat (2 + 3 * div) @(negedge clk);
        chk("R5 started", longint'(rises > r0), 1);
        chk_le("R5 start latency ps", ps(first_rise - t_wr), longint'(2 + 3 * div) * 5000);
        measure(div, (code == 0) ? "R3 code0" : "R2 code");
        bus_write(GATE, $urandom_range(127, 0));
        repeat (3 * div) @(negedge clk);
        chk("R6 low after stop", longint'(dclk), 0);
        r1 = rises;
        repeat (2 * div + 4) @(negedge clk);
        chk("R6 stays stopped", rises - r1, 0);
        mark = 0;
    endtask

    initial begin
        int rd, r0, code;
        realtime t0, t1, t2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        watch = 1;
        // R1: reset state
        bus_read(RATIO, rd); chk("R1 ratio reg after reset", rd, 0);
        bus_read(GATE, rd);  chk("R1 gate reg after reset", rd, 0);
        repeat (10) @(negedge clk);
        chk("R1 no output edges", rises, 0);
        chk("R1 output low", longint'(dclk), 0);

        // R4: unused bits read zero, writes to them ignored
        bus_write(GATE, 'h7F);
        bus_read(GATE, rd); chk("R4 gate unused bits", rd, 0);
        repeat (8) @(negedge clk);
        chk("R4 gate unused write no start", rises, 0);
        bus_write(RATIO, 'hF8);
        bus_read(RATIO, rd); chk("R4 ratio unused bits", rd, 0);

        // R2/R3/R5/R6: every code directed
        for (int c = 0; c < 8; c++) run_case(c);
        // seeded random codes
        for (int i = 0; i < 12; i++) run_case($urandom_range(7, 0));

        // R8: ratio write while running is deferred to period end
        bus_write(RATIO, 7);
        bus_write(GATE, 'h80);
        @(posedge dclk) t0 = $realtime;
        repeat (5) @(negedge clk);
        bus_write(RATIO, 2);
        bus_read(RATIO, rd); chk("R8 immediate readback", rd, 2);
        @(posedge dclk) t1 = $realtime;
        chk("R8 old period kept ps", ps(t1 - t0), 64 * 5000);
        @(posedge dclk) t2 = $realtime;
        chk("R8 new period ps", ps(t2 - t1), 2 * 5000);
        bus_write(GATE, 0);
        repeat (20) @(negedge clk);

        // R9: foreign addresses
        bus_write(RATIO, 3);
        bus_write(RATIO + 'h100, 5);
        bus_write(RATIO + 1, 6);
        bus_write(GATE - 'h100, 'h80);
        bus_read(RATIO, rd); chk("R9 ratio untouched", rd, 3);
        bus_read(GATE, rd);  chk("R9 gate untouched", rd, 0);
        bus_read(RATIO + 'h100, rd); chk("R9 foreign read zero", rd, 0);
        bus_read(BASE + 'h44, rd);   chk("R9 gap read zero", rd, 0);
        bus_write(GATE, 'h80);
        bus_write(GATE + 'h100, 0);
        r0 = rises;
        repeat (20) @(negedge clk);
        chk("R9 foreign clear ignored", longint'(rises > r0), 1);
        measure(4, "R9 code3");
        bus_write(GATE, 0);
        repeat (20) @(negedge clk);

        chk("R7 no runt pulses", runts, 0);
        code = 0;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule